// File: doc/BRIEF.md
# Quantizing Phase-Step Tap Selector

This block turns a stream of fine phase-step commands into a delay-line tap index. Each command moves a requested phase target one step forward or backward. A step is 1/256 of the clock period. The target is held in a signed, saturating accumulator. A separate calibration value gives the number of physical taps that together span exactly one clock period. The block outputs the tap whose delay lies nearest to the requested phase.

Requested phase and physical tap are decoupled. When the delay line has fewer taps per period than there are phase steps, some commands leave the tap where it is. When it has more, one command can skip over several taps. The effective resolution is therefore whichever is coarser: one phase step or one tap.

A one-cycle completion pulse follows each accepted command after a fixed latency. Commands that arrive while a previous one is in flight are dropped. The analog line, its calibration loop and any sweep sequencer sit outside this block.

Top module: `phase_tap_ctrl`

## Requirements
- R1: While reset is held, and on release, `phase` reads 0, `tap_sel` reads 0 and `cmd_done` is low.
- R2: An accepted command with `cmd_dir`=1 raises `phase` by one step. With `cmd_dir`=0 it lowers `phase` by one step. The new value is visible one cycle after acceptance.
- R3: `phase` saturates at +255 and at -255. A command that would pass a limit leaves `phase` unchanged but is still acknowledged with `cmd_done`.
- R4: For a non-negative phase p and taps-per-period n > 0, `tap_sel` = q mod n, where q = floor((p*n + 128)/256). This is the nearest tap, with an exact half rounding up.
- R5: For a negative phase p, q is computed from |p| in the same way (a half rounds away from zero), and `tap_sel` = (n - q) mod n. This counts backward from tap 0.
- R6: A command is accepted only when no earlier command is in flight. A strobe seen during the in-flight window does not change `phase` and produces no extra `cmd_done`.
- R7: `cmd_done` is a one-cycle pulse raised DONE_LAT (default 2) cycles after the accepting edge. At that point `tap_sel` already reflects the new phase. A command may be accepted in the cycle where `cmd_done` is high.
- R8: `tap_sel` follows the current `phase` and `cal_taps` one cycle later. A change of `cal_taps` alone recomputes `tap_sel` without moving `phase`.
- R9: When `cal_taps` is 0, `tap_sel` is 0.
- R10: With fewer than 256 taps per period, a command can leave `tap_sel` unchanged. With more than 256 taps per period, one command can move `tap_sel` by more than one tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Phase-step command strobe |
| cmd_dir | input | 1 | Step direction: 1 forward, 0 backward |
| cal_taps | input | TAP_W (10) | Calibrated number of taps spanning one clock period |
| cmd_done | output | 1 | One-cycle completion pulse |
| phase | output | FRAC_BITS+1 (9) | Signed requested phase in 1/256-period steps |
| tap_sel | output | TAP_W (10) | Nearest tap index for the requested phase |

## Verification
The phase update is due one cycle after the accepting edge. The tap is due one cycle after any change of phase or calibration. The completion pulse is due DONE_LAT cycles after acceptance.

The bench counts clock edges and stamps each queued expectation with the accepting edge number. When the pulse appears, the monitor compares that stamp against the edge count. Phase, tap and latency are all checked on the falling edge where the pulse is seen. Calibration changes are checked on the falling edge that follows the first rising edge after the new value is driven.

// File: rtl/phase_tap_pkg.sv
package phase_tap_pkg;
  typedef enum logic {
    STEP_BACK = 1'b0,
    STEP_FWD  = 1'b1
  } step_dir_e;
endpackage

// File: rtl/phase_step_accum.sv
module phase_step_accum
  import phase_tap_pkg::*;
#(
  parameter int FRAC_BITS = 8,
  parameter int DONE_LAT  = 2,
  localparam int PHASE_W  = FRAC_BITS + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic                      cmd_dir,
  output logic signed [PHASE_W-1:0] phase_o,
  output logic                      accept_o,
  output logic                      busy_o,
  output logic                      done_o
);
  localparam int PHASE_LIM = (1 << FRAC_BITS) - 1;
  localparam int CNT_W     = $clog2(DONE_LAT + 1);

  logic [CNT_W-1:0] wait_cnt;

  // Saturating single-step move of the phase target.
  function automatic logic signed [PHASE_W-1:0] step_phase(
    input logic signed [PHASE_W-1:0] cur,
    input logic                      dir
  );
    int v;
    v = int'(cur);
    if (step_dir_e'(dir) == STEP_FWD) begin
      if (v < PHASE_LIM) v = v + 1;
    end else begin
      if (v > -PHASE_LIM) v = v - 1;
    end
    return PHASE_W'(v);
  endfunction

  assign busy_o   = (wait_cnt != '0);
  assign accept_o = cmd_valid && !busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_o  <= '0;
      wait_cnt <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) begin
        phase_o  <= step_phase(phase_o, cmd_dir);
        wait_cnt <= CNT_W'(DONE_LAT);
      end else if (busy_o) begin
        wait_cnt <= wait_cnt - 1'b1;
        if (wait_cnt == CNT_W'(1)) done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/phase_tap_quant.sv
module phase_tap_quant #(
  parameter int FRAC_BITS = 8,
  parameter int TAP_W     = 10,
  localparam int PHASE_W  = FRAC_BITS + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [PHASE_W-1:0] phase_i,
  input  logic [TAP_W-1:0]          taps_i,
  output logic [TAP_W-1:0]          tap_o
);
  localparam int PROD_W = FRAC_BITS + TAP_W + 1;

  // Nearest tap: round(|p|*n/2^FRAC_BITS) half away from zero, then fold
  // negative phases backward from tap 0 modulo n.
  function automatic logic [TAP_W-1:0] nearest_tap(
    input logic signed [PHASE_W-1:0] ph,
    input logic [TAP_W-1:0]          n
  );
    logic [PHASE_W-1:0] mag;
    logic [PROD_W-1:0]  prod;
    logic [TAP_W:0]     q;
    logic [TAP_W-1:0]   wrapped;
    mag     = ph[PHASE_W-1] ? PHASE_W'(-ph) : PHASE_W'(ph);
    prod    = PROD_W'(mag) * PROD_W'(n) + PROD_W'(1 << (FRAC_BITS - 1));
    q       = (TAP_W + 1)'(prod >> FRAC_BITS);
    wrapped = (q >= (TAP_W + 1)'(n)) ? '0 : q[TAP_W-1:0];
    if (n == '0)                              return '0;
    else if (ph[PHASE_W-1] && wrapped != '0) return n - wrapped;
    else                                      return wrapped;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) tap_o <= '0;
    else        tap_o <= nearest_tap(phase_i, taps_i);
  end
endmodule

// File: rtl/phase_tap_ctrl.sv
module phase_tap_ctrl #(
  parameter int FRAC_BITS = 8,
  parameter int TAP_W     = 10,
  parameter int DONE_LAT  = 2,
  localparam int PHASE_W  = FRAC_BITS + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic                      cmd_dir,
  input  logic [TAP_W-1:0]          cal_taps,
  output logic                      cmd_done,
  output logic signed [PHASE_W-1:0] phase,
  output logic [TAP_W-1:0]          tap_sel
);
  // Named internal events, observed by the bound checker.
  logic cmd_accept;
  logic cmd_busy;

  phase_step_accum #(
    .FRAC_BITS (FRAC_BITS),
    .DONE_LAT  (DONE_LAT)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_dir   (cmd_dir),
    .phase_o   (phase),
    .accept_o  (cmd_accept),
    .busy_o    (cmd_busy),
    .done_o    (cmd_done)
  );

  phase_tap_quant #(
    .FRAC_BITS (FRAC_BITS),
    .TAP_W     (TAP_W)
  ) u_quant (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase),
    .taps_i  (cal_taps),
    .tap_o   (tap_sel)
  );
endmodule

// File: rtl/phase_tap_chk.sv
module phase_tap_chk #(
  parameter int FRAC_BITS = 8,
  parameter int TAP_W     = 10,
  localparam int PHASE_W  = FRAC_BITS + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic                      cmd_dir,
  input logic                      cmd_accept,
  input logic                      cmd_busy,
  input logic                      cmd_done,
  input logic signed [PHASE_W-1:0] phase,
  input logic [TAP_W-1:0]          tap_sel,
  input logic [TAP_W-1:0]          cal_taps
);
  localparam int LIM = (1 << FRAC_BITS) - 1;

  a_r2_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_dir && int'(phase) != LIM)
      |=> int'(phase) == int'($past(phase)) + 1);

  a_r2_back_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !cmd_dir && int'(phase) != -LIM)
      |=> int'(phase) == int'($past(phase)) - 1);

  a_r3_phase_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(phase) <= LIM) && (int'(phase) >= -LIM));

  a_r6_ignore_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy || !cmd_valid) |=> $stable(phase));

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(cmd_busy));

  a_r5_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cal_taps) != '0) |-> (tap_sel < $past(cal_taps)));

  a_r8_tap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(phase) && $stable(cal_taps)) |=> $stable(tap_sel));

  a_r9_zero_cal: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cal_taps) == '0) |-> (tap_sel == '0));
endmodule

bind phase_tap_ctrl phase_tap_chk #(
  .FRAC_BITS (FRAC_BITS),
  .TAP_W     (TAP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_dir    (cmd_dir),
  .cmd_accept (cmd_accept),
  .cmd_busy   (cmd_busy),
  .cmd_done   (cmd_done),
  .phase      (phase),
  .tap_sel    (tap_sel),
  .cal_taps   (cal_taps)
);

// File: tb/sim_phase_tap_ctrl.sv
`timescale 1ns/1ps
module sim_phase_tap_ctrl;
  localparam int LAT = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_dir = 1'b0;
  logic [9:0]        cal_taps = 10'd200;
  logic              cmd_done;
  logic signed [8:0] phase;
  logic [9:0]        tap_sel;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int model_phase = 0;
  int model_taps = 200;
  int exp_phase_q[$];
  int exp_tap_q[$];
  int exp_cyc_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phase_tap_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_dir   (cmd_dir),
    .cal_taps  (cal_taps),
    .cmd_done  (cmd_done),
    .phase     (phase),
    .tap_sel   (tap_sel)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: real-valued nearest tap, halves away from zero, wrapped mod n.
  function automatic int ref_tap(input int p, input int n);
    real x;
    int  r;
    if (n == 0) return 0;
    x = (p * n) / 256.0;
    if (x >= 0.0) r = $rtoi($floor(x + 0.5));
    else          r = -$rtoi($floor(-x + 0.5));
    r = r % n;
    if (r < 0) r = r + n;
    return r;
  endfunction

  function automatic void model_step(input bit fwd);
    if (fwd && model_phase < 255)       model_phase++;
    else if (!fwd && model_phase > -255) model_phase--;
  endfunction

  // Driver: one command, expectation pushed with its accepting edge number.
  task automatic step(input bit fwd);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_dir   = fwd;
    model_step(fwd);
    exp_phase_q.push_back(model_phase);
    exp_tap_q.push_back(ref_tap(model_phase, model_taps));
    exp_cyc_q.push_back(cyc + 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (LAT) @(negedge clk);
  endtask

  task automatic set_cal(input int n);
    @(negedge clk);
    cal_taps   = 10'(n);
    model_taps = n;
    @(negedge clk);
    chk("R8 tap after cal change", int'(tap_sel), ref_tap(model_phase, n));
    chk("R8 phase kept on cal change", int'(phase), model_phase);
  endtask

  // Monitor: compares each done pulse against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && cmd_done) begin
      if (exp_phase_q.size() == 0) begin
        chk("R6/R7 unexpected done", 1, 0);
      end else begin
        chk("R2 phase at done", int'(phase), exp_phase_q.pop_front());
        chk("R4 tap at done", int'(tap_sel), exp_tap_q.pop_front());
        chk("R7 done latency", cyc, exp_cyc_q.pop_front() + LAT);
      end
    end
  end

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 tap in reset", int'(tap_sel), 0);
    chk("R1 done in reset", int'(cmd_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 phase after reset", int'(phase), 0);
    chk("R1 tap after reset", int'(tap_sel), 0);

    // 200 taps per period: steps 2 and 3 both land on tap 2.
    step(1'b1);
    step(1'b1);
    chk("R10 tap after step 2", int'(tap_sel), 2);
    step(1'b1);
    chk("R10 tap unchanged after step 3", int'(tap_sel), 2);
    step(1'b1);
    step(1'b1);

    // 500 taps per period: a single step jumps two taps.
    set_cal(500);
    chk("R8 recomputed tap", int'(tap_sel), 10);
    step(1'b1);
    chk("R10 two-tap jump", int'(tap_sel), 12);

    // Negative phases at 100 taps per period.
    set_cal(100);
    for (int i = 0; i < 10; i++) step(1'b0);
    chk("R5 negative phase", int'(phase), -4);
    chk("R5 backward tap", int'(tap_sel), 98);

    // Strobe held through the in-flight window: only one acceptance.
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_dir   = 1'b1;
    model_step(1'b1);
    exp_phase_q.push_back(model_phase);
    exp_tap_q.push_back(ref_tap(model_phase, model_taps));
    exp_cyc_q.push_back(cyc + 1);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 held strobe accepted once", int'(phase), -3);

    // Halfway ties at 128 taps per period.
    set_cal(128);
    chk("R5 negative tie away from zero", int'(tap_sel), 126);
    for (int i = 0; i < 4; i++) step(1'b1);
    chk("R4 positive tie rounds up", int'(tap_sel), 1);

    // Saturation at both limits, with the wrap at 100 taps per period.
    set_cal(100);
    for (int i = 0; i < 260; i++) step(1'b1);
    chk("R3 upper limit", int'(phase), 255);
    chk("R4 wrap to tap 0", int'(tap_sel), 0);
    for (int i = 0; i < 515; i++) step(1'b0);
    chk("R3 lower limit", int'(phase), -255);
    set_cal(256);
    chk("R5 tap at lower limit", int'(tap_sel), 1);

    set_cal(0);
    chk("R9 zero calibration", int'(tap_sel), 0);
    step(1'b1);
    chk("R9 zero calibration after step", int'(tap_sel), 0);

    repeat (4) @(negedge clk);
    chk("R7 all done pulses seen", exp_phase_q.size(), 0);
    report();
  end
endmodule